// File: doc/BRIEF.md
# Display Fetch Address Remapper

This block sits in the refresh path of a display controller. A small counter walks the screen: each character clock moves one character along the line. Each scanline of a character row reuses the same run of addresses, and the row-scan counter steps after the last character of a line. The block turns the resulting linear address into the physical video memory offset that the display fetch uses.

Three transforms are applied, controlled by mode bits. The first is an optional rotation for word or doubleword addressing, which puts high address bits into the low positions and wraps at 64K. The second optionally replaces address bits 13 and 14 with the low bits of the row-scan counter, which gives the interleaved banks of legacy graphics layouts. The third forms the planar offset from the address and the plane index. A CPU access presented on the same port takes priority and bypasses all of the remapping.

The mode bits, start address, line length and last scanline are captured only on a frame-start pulse, so a frame is always fetched in a single mode. The result and a valid flag are registered.

Top module: `vmem_addr_remap`

## Requirements
- R1: When `no_rotate` is 1, or `width_mode` is 2'b00 (byte), the display address reaches the substitution stage unrotated.
- R2: With `width_mode` 2'b01 (word) and `no_rotate` 0, the address becomes ((A×2) mod 65536) + bit 13 of A.
- R3: With `width_mode` 2'b10 or 2'b11 (doubleword) and `no_rotate` 0, the address becomes ((A×4) mod 65536) + bits 13:12 of A, placed in bits 1:0.
- R4: When `keep_b13` is 0, bit 13 of the rotated address is replaced by bit 0 of the row-scan count. When it is 1, bit 13 is unchanged.
- R5: When `keep_b14` is 0, bit 14 of the rotated address is replaced by bit 1 of the row-scan count. When it is 1, bit 14 is unchanged.
- R6: Substitution acts on the result of the rotation, never on the unrotated address.
- R7: `mem_off` = (final address × 4 + `plane`) mod 262144. The plane occupies bits 1:0.
- R8: When `cpu_sel` is 1, `mem_off` = `cpu_addr`×4 + `plane`, with no rotation or substitution. The character counter does not advance in that cycle.
- R9: The display address is (start + row base + character index) mod 65536. The character index wraps after `chars_per_line`−1. The row-scan count then steps, and after `max_scan` it returns to 0 while the row base grows by `chars_per_line`.
- R10: The mode bits, start address, line length and last scanline take effect only in the cycle where `frame_start` is 1. That pulse also clears all counters, and changes between pulses have no effect.
- R11: `out_valid` is 1 exactly one cycle after a cycle that had `cpu_sel`=1, or had `fetch_en`=1 with `frame_start`=0. `mem_off` carries that cycle's result.
- R12: After reset, `out_valid` and `mem_off` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Captures configuration and clears counters |
| fetch_en | input | 1 | Character clock for a display fetch |
| cpu_sel | input | 1 | CPU access this cycle (priority, bypass) |
| cpu_addr | input | 16 | CPU linear address |
| plane | input | 2 | Plane index 0..3 |
| start_addr | input | 16 | Frame start address |
| chars_per_line | input | 8 | Characters per scanline |
| max_scan | input | 5 | Last row-scan value of a character row |
| width_mode | input | 2 | 00 byte, 01 word, 1x doubleword |
| no_rotate | input | 1 | 1 disables the rotation |
| keep_b13 | input | 1 | 0 puts row-scan bit 0 on address bit 13 |
| keep_b14 | input | 1 | 0 puts row-scan bit 1 on address bit 14 |
| mem_off | output | 18 | Registered planar memory offset |
| out_valid | output | 1 | Registered valid flag |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 2-bit plane, 8-bit line length and 5-bit scan count. These widths put the 64K wrap and both substituted bits within reach. The bench runs every mix of width mode, rotation bit and the two substitution bits. It uses three characters per line and scan values 0 to 3, with start addresses chosen so that bits 12 to 14 change and the 16-bit sum wraps. A behavioural model is compared on every clock. Further phases mix in CPU cycles, change the mode in the middle of a frame, and insert idle and frame-start cycles.

// File: rtl/vram_remap_pkg.sv
// Package: shared types for the display fetch address remapper.
// Assumes: width codes are decoded as listed; code 2'b11 aliases doubleword.
package vram_remap_pkg;

    typedef enum logic [1:0] {
        FETCH_BYTE  = 2'b00,
        FETCH_WORD  = 2'b01,
        FETCH_DWORD = 2'b10,
        FETCH_DWALT = 2'b11
    } fetch_width_e;

    typedef struct packed {
        fetch_width_e width;
        logic         no_rotate;
        logic         keep_b13;
        logic         keep_b14;
    } remap_ctrl_t;

endpackage

// File: rtl/scan_addr_counter.sv
// Module: scan_addr_counter
// Walks characters along a line and row-scan values within a character row,
// and produces the linear display address start + row_base + char_idx.
// Assumes: char_tick never coincides with frame_start (top gates it).
module scan_addr_counter #(
    parameter int ADDR_W = 16,
    parameter int CHAR_W = 8,
    parameter int SCAN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              char_tick,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CHAR_W-1:0] chars_per_line,
    input  logic [SCAN_W-1:0] max_scan,
    output logic [ADDR_W-1:0] disp_addr,
    output logic [SCAN_W-1:0] row_scan
);

    localparam int IDX_W = CHAR_W + 1;

    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] row_base_q;
    logic [CHAR_W-1:0] cpl_q;
    logic [CHAR_W-1:0] char_q;
    logic [SCAN_W-1:0] max_q;
    logic [SCAN_W-1:0] scan_q;
    logic [IDX_W-1:0]  char_next;
    logic              line_end;

    // Detect the last character of a scanline.
    always_comb begin
        char_next = {1'b0, char_q} + IDX_W'(1);
        line_end  = (char_next >= {1'b0, cpl_q});
    end

    // Capture the frame geometry and step the character and row-scan counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q    <= '0;
            row_base_q <= '0;
            cpl_q      <= '0;
            char_q     <= '0;
            max_q      <= '0;
            scan_q     <= '0;
        end else if (frame_start) begin
            start_q    <= start_addr;
            cpl_q      <= chars_per_line;
            max_q      <= max_scan;
            row_base_q <= '0;
            char_q     <= '0;
            scan_q     <= '0;
        end else if (char_tick) begin
            if (line_end) begin
                char_q <= '0;
                if (scan_q >= max_q) begin
                    scan_q     <= '0;
                    row_base_q <= row_base_q + ADDR_W'(cpl_q);
                end else begin
                    scan_q <= scan_q + SCAN_W'(1);
                end
            end else begin
                char_q <= char_q + CHAR_W'(1);
            end
        end
    end

    // Form the linear display address (wraps at the address width).
    always_comb begin
        disp_addr = start_q + row_base_q + ADDR_W'(char_q);
        row_scan  = scan_q;
    end

    // R9: the row-scan count never passes the captured last scanline.
    p_scan_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_q <= max_q);

    // R9: the character index stays below the captured line length.
    p_char_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_q != '0) |-> (char_q < cpl_q));

endmodule

// File: rtl/addr_rotator.sv
// Module: addr_rotator
// Rotates the display address for word or doubleword fetch widths. Upper bits
// fall off at the address width, and the chosen high bits fill the vacated
// low bits.
// Assumes: ADDR_W > DW_SRC + 1 and ADDR_W > WORD_SRC.
module addr_rotator
    import vram_remap_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WORD_SRC = 13,
    parameter int DW_SRC   = 12
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  fetch_width_e      width,
    input  logic              no_rotate,
    output logic [ADDR_W-1:0] addr_out
);

    // Select pass-through, one-bit or two-bit rotation.
    always_comb begin
        addr_out = addr_in;
        if (!no_rotate) begin
            unique case (width)
                FETCH_BYTE: addr_out = addr_in;
                FETCH_WORD: addr_out = {addr_in[ADDR_W-2:0], addr_in[WORD_SRC]};
                default:    addr_out = {addr_in[ADDR_W-3:0], addr_in[DW_SRC+1:DW_SRC]};
            endcase
        end
    end

endmodule

// File: rtl/scan_bit_subst.sv
// Module: scan_bit_subst
// Replaces SUB_N consecutive address bits, starting at LO_BIT, with the low
// row-scan bits wherever the matching keep bit is 0.
// Assumes: LO_BIT + SUB_N <= ADDR_W and SUB_N <= SCAN_W.
module scan_bit_subst #(
    parameter int ADDR_W = 16,
    parameter int SCAN_W = 5,
    parameter int LO_BIT = 13,
    parameter int SUB_N  = 2
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [SCAN_W-1:0] row_scan,
    input  logic [SUB_N-1:0]  keep,
    output logic [ADDR_W-1:0] addr_out
);

    logic [SUB_N-1:0] sub_bits;

    // One selector per substituted bit position.
    for (genvar k = 0; k < SUB_N; k++) begin : g_sel
        assign sub_bits[k] = keep[k] ? addr_in[LO_BIT+k] : row_scan[k];
    end

    // Merge the selected bits back into the address.
    always_comb begin
        addr_out = addr_in;
        addr_out[LO_BIT+SUB_N-1:LO_BIT] = sub_bits;
    end

endmodule

// File: rtl/vmem_addr_remap.sv
// Module: vmem_addr_remap (top)
// Display fetch address path. Counter -> rotation -> row-scan substitution ->
// planar offset -> output register. A CPU access bypasses the remap and takes
// priority over a fetch in the same cycle.
// Assumes: configuration inputs matter only in a frame_start cycle.
module vmem_addr_remap
    import vram_remap_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int PLANE_W = 2,
    parameter int CHAR_W  = 8,
    parameter int SCAN_W  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start,
    input  logic                      fetch_en,
    input  logic                      cpu_sel,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [PLANE_W-1:0]        plane,
    input  logic [ADDR_W-1:0]         start_addr,
    input  logic [CHAR_W-1:0]         chars_per_line,
    input  logic [SCAN_W-1:0]         max_scan,
    input  logic [1:0]                width_mode,
    input  logic                      no_rotate,
    input  logic                      keep_b13,
    input  logic                      keep_b14,
    output logic [ADDR_W+PLANE_W-1:0] mem_off,
    output logic                      out_valid
);

    localparam int OFF_W  = ADDR_W + PLANE_W;
    localparam int SUB_LO = 13;
    localparam int SUB_N  = 2;

    remap_ctrl_t       ctrl_q;
    logic              char_tick;
    logic              take_valid;
    logic [ADDR_W-1:0] disp_addr;
    logic [SCAN_W-1:0] row_scan;
    logic [ADDR_W-1:0] rot_addr;
    logic [ADDR_W-1:0] sub_addr;
    logic [ADDR_W-1:0] sel_addr;

    // A display character clock happens only without CPU access or frame start.
    always_comb begin
        char_tick  = fetch_en && !cpu_sel && !frame_start;
        take_valid = cpu_sel || char_tick;
    end

    // Capture the mode bits once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (frame_start) begin
            ctrl_q <= '{width: fetch_width_e'(width_mode), no_rotate: no_rotate,
                        keep_b13: keep_b13, keep_b14: keep_b14};
        end
    end

    scan_addr_counter #(
        .ADDR_W (ADDR_W),
        .CHAR_W (CHAR_W),
        .SCAN_W (SCAN_W)
    ) i_counter (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_start    (frame_start),
        .char_tick      (char_tick),
        .start_addr     (start_addr),
        .chars_per_line (chars_per_line),
        .max_scan       (max_scan),
        .disp_addr      (disp_addr),
        .row_scan       (row_scan)
    );

    addr_rotator #(
        .ADDR_W (ADDR_W)
    ) i_rotate (
        .addr_in   (disp_addr),
        .width     (ctrl_q.width),
        .no_rotate (ctrl_q.no_rotate),
        .addr_out  (rot_addr)
    );

    scan_bit_subst #(
        .ADDR_W (ADDR_W),
        .SCAN_W (SCAN_W),
        .LO_BIT (SUB_LO),
        .SUB_N  (SUB_N)
    ) i_subst (
        .addr_in  (rot_addr),
        .row_scan (row_scan),
        .keep     ({ctrl_q.keep_b14, ctrl_q.keep_b13}),
        .addr_out (sub_addr)
    );

    // The CPU path uses the untouched address.
    always_comb begin
        sel_addr = cpu_sel ? cpu_addr : sub_addr;
    end

    // Register the planar offset and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_off   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= take_valid;
            if (take_valid) begin
                mem_off <= {sel_addr, plane};
            end
        end
    end

    // R8: a CPU cycle yields its own address and plane one cycle later.
    p_cpu_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_sel |=> (out_valid && mem_off == {$past(cpu_addr), $past(plane)}));

    // R7: the plane index lands in the low bits of every valid result.
    p_plane_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |=> (mem_off[PLANE_W-1:0] == $past(plane)));

    // R10: captured mode bits change only on a frame-start pulse.
    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(ctrl_q));

    // R11: nothing requested means no valid result next cycle.
    p_idle_invalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_sel && (!fetch_en || frame_start)) |=> !out_valid);

    // R4: with bit 13 substitution on, the result bit follows row-scan bit 0.
    p_b13_scan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (char_tick && !ctrl_q.keep_b13) |=> (mem_off[PLANE_W+SUB_LO] == $past(row_scan[0])));

    // R5: with bit 14 substitution on, the result bit follows row-scan bit 1.
    p_b14_scan_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (char_tick && !ctrl_q.keep_b14) |=> (mem_off[PLANE_W+SUB_LO+1] == $past(row_scan[1])));

endmodule

// File: tb/test_vmem_addr_remap.sv
module test_vmem_addr_remap;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_start, fetch_en, cpu_sel;
    logic [15:0] cpu_addr, start_addr;
    logic [1:0]  plane, width_mode;
    logic [7:0]  chars_per_line;
    logic [4:0]  max_scan;
    logic        no_rotate, keep_b13, keep_b14;
    logic [17:0] mem_off;
    logic        out_valid;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    string cur_tag = "R1";

    // Behavioural model state
    int m_start, m_cpl, m_max, m_base, m_char, m_scan;
    int m_wmode, m_norot, m_k13, m_k14;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmem_addr_remap i_vmem_addr_remap (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .fetch_en(fetch_en),
        .cpu_sel(cpu_sel), .cpu_addr(cpu_addr), .plane(plane), .start_addr(start_addr),
        .chars_per_line(chars_per_line), .max_scan(max_scan), .width_mode(width_mode),
        .no_rotate(no_rotate), .keep_b13(keep_b13), .keep_b14(keep_b14),
        .mem_off(mem_off), .out_valid(out_valid)
    );

    function automatic int bitval(int v, int pos);
        return (v / (1 << pos)) % 2;
    endfunction

    function automatic int remap(int a, int scan);
        int r = a;
        if (m_norot == 0 && m_wmode == 1) r = (a * 2) % 65536 + bitval(a, 13);
        else if (m_norot == 0 && m_wmode >= 2) r = (a * 4) % 65536 + (a / 4096) % 4;
        if (m_k13 == 0) r = r - bitval(r, 13) * 8192 + (scan % 2) * 8192;
        if (m_k14 == 0) r = r - bitval(r, 14) * 16384 + ((scan / 2) % 2) * 16384;
        return r;
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // One clock: drive inputs, predict, advance the model, sample after the edge.
    task automatic tick(input bit fs, input bit fe, input bit cs, input int ca, input int pl);
        bit exp_v;
        int exp_off;
        frame_start = fs; fetch_en = fe; cpu_sel = cs;
        cpu_addr = ca[15:0]; plane = pl[1:0];
        exp_v = cs || (fe && !fs);
        exp_off = -1;
        if (cs) exp_off = ca * 4 + pl;
        else if (exp_v) exp_off = (remap((m_start + m_base + m_char) % 65536, m_scan) * 4 + pl) % 262144;
        if (fs) begin
            m_start = start_addr; m_cpl = chars_per_line; m_max = max_scan;
            m_wmode = width_mode; m_norot = no_rotate; m_k13 = keep_b13; m_k14 = keep_b14;
            m_base = 0; m_char = 0; m_scan = 0;
        end else if (fe && !cs) begin
            if (m_char + 1 >= m_cpl) begin
                m_char = 0;
                if (m_scan >= m_max) begin
                    m_scan = 0;
                    m_base = (m_base + m_cpl) % 65536;
                end else m_scan++;
            end else m_char++;
        end
        @(posedge clk);
        #1;
        check({cur_tag, " valid (R11)"}, int'(out_valid), int'(exp_v));
        if (exp_v) begin
            check(cur_tag, int'(mem_off), exp_off);
            check("R7 plane bits", int'(mem_off[1:0]), pl);
        end
    endtask

    function automatic string tag_for(int wm, int nr, int k13, int k14);
        if (k13 == 0 || k14 == 0) begin
            if (nr == 0 && wm != 0) return "R6";
            return (k14 == 0) ? "R5" : "R4";
        end
        if (nr == 1 || wm == 0) return "R1";
        return (wm == 1) ? "R2" : "R3";
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; frame_start = 0; fetch_en = 0; cpu_sel = 0;
        cpu_addr = 0; plane = 0; start_addr = 0; chars_per_line = 3; max_scan = 3;
        width_mode = 0; no_rotate = 0; keep_b13 = 1; keep_b14 = 1;
        m_start = 0; m_cpl = 0; m_max = 0; m_base = 0; m_char = 0; m_scan = 0;
        m_wmode = 0; m_norot = 0; m_k13 = 1; m_k14 = 1;
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        check("R12 valid", int'(out_valid), 0);
        check("R12 offset", int'(mem_off), 0);
        rst_n = 1'b1;

        // All mode mixes, scan 0..3, crossing bits 12..14 and the 64K wrap (R9)
        for (int c = 0; c < 24; c++) begin
            int wm = c % 3, nr = (c / 3) % 2, k13 = (c / 6) % 2, k14 = (c / 12) % 2;
            width_mode = wm[1:0]; no_rotate = nr[0]; keep_b13 = k13[0]; keep_b14 = k14[0];
            start_addr = 16'(32'hFFF0 + c * 32'h0A53);
            chars_per_line = 3; max_scan = 3;
            cur_tag = tag_for(wm, nr, k13, k14);
            tick(1, 0, 0, 0, 0);
            for (int i = 0; i < 28; i++) tick(0, 1, 0, 0, i % 4);
        end
        width_mode = 3; no_rotate = 0; keep_b13 = 1; keep_b14 = 1;
        cur_tag = "R3 alias";
        tick(1, 0, 0, 0, 0);
        for (int i = 0; i < 12; i++) tick(0, 1, 0, 0, 3);

        // R9: longer lines and a shorter row
        cur_tag = "R9";
        width_mode = 0; no_rotate = 1; start_addr = 16'h3FFA; chars_per_line = 5; max_scan = 1;
        tick(1, 0, 0, 0, 0);
        for (int i = 0; i < 30; i++) tick(0, 1, 0, 0, 1);

        // R10: configuration changed in the middle of a frame has no effect
        cur_tag = "R10";
        width_mode = 1; no_rotate = 0; keep_b13 = 0; keep_b14 = 1;
        start_addr = 16'h2ABC; chars_per_line = 4; max_scan = 2;
        tick(1, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) tick(0, 1, 0, 0, 2);
        width_mode = 2; keep_b13 = 1; keep_b14 = 0; no_rotate = 1;
        start_addr = 16'h0000; chars_per_line = 1; max_scan = 0;
        for (int i = 0; i < 14; i++) tick(0, 1, 0, 0, 2);

        // R8: CPU accesses interleaved, counters hold
        cur_tag = "R8";
        width_mode = 2; no_rotate = 0; keep_b13 = 0; keep_b14 = 0;
        start_addr = 16'h7F00; chars_per_line = 3; max_scan = 3;
        tick(1, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) begin
            if (i % 3 == 1) tick(0, 1, 1, 16'hE001 + i * 16'h0111, i % 4);
            else tick(0, 1, 0, 0, i % 4);
        end
        tick(0, 0, 1, 16'hFFFF, 3);

        // R11: idle gaps and a frame start with fetch_en high
        cur_tag = "R11";
        for (int i = 0; i < 12; i++) tick(0, (i % 2 == 0), 0, 0, 1);
        tick(1, 1, 0, 0, 0);
        for (int i = 0; i < 4; i++) tick(0, 1, 0, 0, 0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule